// File: doc/BRIEF.md
# Two-Speed CPU Cycle Stretcher

This block produces the processor phase clock for a CPU that normally runs at 2MHz. The CPU can also reach a slow peripheral region that is timed by a free-running 1MHz bus enable. Everything runs from one 8MHz system clock. One tick is 125ns, so a 2MHz half-phase is 2 ticks and a 1MHz period is 8 ticks. All outputs are levels or one-tick strobes; none is a gated clock.

A 3-bit phase counter starts at phase 0 in the first tick after reset and counts up each tick. The 1MHz enable is high in phases 4 to 7 and falls at the wrap back to 0. That wrap is the only edge the CPU clock and the 1MHz enable share.

A CPU cycle always begins at phase 0 or phase 4. In the first tick of a cycle the block samples the address, the read/write line and a bus-activity flag:
- A fast cycle is 2 ticks low and 2 ticks high.
- A slow cycle (active and inside the slow region) ends with 2 low ticks and 6 high ticks, closing on the shared edge. When the cycle began at phase 4, 4 more low ticks are added in front.

The slow device's active-low select is asserted only while the CPU clock is high in a slow cycle, so the device sees exactly one enable pulse per access. A separate control bit sets the rate of the video character clock enable.

The controller has five states:
- `ST_LOW`: the first low half of any cycle, in which the inputs are sampled.
- `ST_HIGH`: the high half of a fast cycle.
- `ST_WAIT`: the extra low time of the odd case.
- `ST_FLOW`: the final 2-tick low phase of an odd stretched cycle.
- `ST_FHIGH`: the 6-tick high phase of a stretched cycle.

Its transitions are:
- LOW to HIGH: at phase 1 or 5 when the cycle is fast.
- LOW to FHIGH: at phase 1 when the cycle is slow (even case).
- LOW to WAIT: at phase 5 when the cycle is slow (odd case).
- WAIT to FLOW: at phase 7.
- FLOW to FHIGH: at phase 1.
- HIGH to LOW: at phase 3 or 7.
- FHIGH to LOW: at phase 7.

Top module: `cycle_stretcher`

## Requirements
- R1: While reset is held and in the first tick after its release, `phi2` is 0, `dev_cs_n` is 1, `e1m` is 0, `cyc_start` is 1, `dev_wr` is 0 and `stall_vld` is 0.
- R2: `e1m` is 1 exactly in phases 4 to 7 of the 8-tick frame counted from reset, whatever the CPU does. `e1m_fall` is 1 exactly in phase 7.
- R3: A fast cycle lasts 4 ticks, with `phi2` 0 for the first 2 ticks and 1 for the last 2.
- R4: A cycle is slow when `bus_act` is 1 and (`cpu_addr` & 16'hFF00) == 16'hFE00 in the cycle's first tick. Any other cycle is fast, including a cycle with `bus_act` at 0 and a slow address.
- R5: A slow cycle ends with 2 ticks of `phi2` at 0 followed by 6 ticks at 1. Its last tick is phase 7, where `phi2_fall` and `e1m_fall` are both 1.
- R6: A slow cycle starting at phase 0 lasts 8 ticks. A slow cycle starting at phase 4 lasts 12 ticks, with `phi2` at 0 for its first 6 ticks.
- R7: `dev_cs_n` is 0 exactly in the ticks where `phi2` is 1 during a slow cycle, and 1 at all other times.
- R8: `dev_wr` pulses for one tick, in the last tick of a slow cycle whose `cpu_rnw` was 0. It never pulses in any other tick.
- R9: `stall_vld` is 1 in the first tick after a slow cycle, with `stall_cnt` equal to that cycle's length minus 4 (4 for the even case, 8 for the odd case). It is 0 after a fast cycle.
- R10: With `vid_fast` at 1, `vid_ce` is 1 in phases 3 and 7. With `vid_fast` at 0, `vid_ce` is 1 in phase 7 only. `vid_fast` has no effect on cycle timing.
- R11: `cyc_start` is 1 only in the first tick of each cycle, and that tick is always phase 0 or 4. `phi2_fall` is 1 only in the last tick of each cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 8MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address, sampled in the first tick of a cycle |
| cpu_rnw | input | 1 | 1 for read, 0 for write, sampled with the address |
| bus_act | input | 1 | 1 when the cycle is a real bus access |
| vid_fast | input | 1 | Selects a 2MHz (1) or 1MHz (0) video character clock enable |
| phi2 | output | 1 | CPU clock level |
| phi2_fall | output | 1 | Last tick of a CPU cycle |
| cyc_start | output | 1 | First tick of a CPU cycle |
| e1m | output | 1 | Free-running 1MHz bus enable level |
| e1m_fall | output | 1 | Last tick of a 1MHz enable period |
| dev_cs_n | output | 1 | Active-low slow-device select, gated by the CPU clock phase |
| dev_wr | output | 1 | Tick in which a slow write is committed |
| vid_ce | output | 1 | Video character clock enable strobe |
| stall_cnt | output | 4 | Extra ticks added to the last slow cycle |
| stall_vld | output | 1 | Strobe marking a new `stall_cnt` value |

## Verification
The bench starts slow cycles at phase 0 and at phase 4. This separates the two stretch lengths, which differ in both the extra low time and the reported stall count.

Addresses just below and just above the slow region, and a slow address with the activity flag cleared, show that the decode and the activity qualifier each decide on their own.

Reads and writes to the slow region show that a write commit appears only for writes, and exactly once per cycle. `vid_fast` changes at random while cycle lengths are checked, which shows that the video rate leaves bus timing unchanged.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int PH_W       = 3;
    localparam int FRAME_TCK  = 1 << PH_W;
    localparam int HALF_TCK   = 2;
    localparam int FAST_TCK   = 2 * HALF_TCK;
    localparam int FINAL_HIGH = FRAME_TCK - HALF_TCK;

    typedef enum logic [2:0] {
        ST_LOW   = 3'd0,
        ST_HIGH  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_FLOW  = 3'd3,
        ST_FHIGH = 3'd4
    } cs_state_e;
endpackage

// File: rtl/cs_phase_gen.sv
module cs_phase_gen
    import cs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vid_fast,
    output logic [PH_W-1:0] ph,
    output logic            e1m,
    output logic            e1m_fall,
    output logic            vid_ce
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_TCK - 1);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(FRAME_TCK / 2 - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_q + 1'b1;
    end

    always_comb begin
        ph       = ph_q;
        e1m      = ph_q[PH_W-1];
        e1m_fall = (ph_q == PH_LAST);
        vid_ce   = (ph_q == PH_LAST) || (vid_fast && (ph_q == PH_MID));
    end

    AST_E1_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e1m) |-> ($past(e1m, 4) && !$past(e1m, 5))) else $error("e1m period"); // R2
    AST_VID_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        vid_ce |-> (vid_fast || e1m_fall)) else $error("vid rate"); // R10
endmodule

// File: rtl/cs_slow_decode.sv
module cs_slow_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] SLOW_BASE = 16'hFE00,
    parameter logic [15:0] SLOW_MASK = 16'hFF00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              act,
    output logic              slow
);
    localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(SLOW_BASE);
    localparam logic [ADDR_W-1:0] MASK_W = ADDR_W'(SLOW_MASK);

    always_comb slow = act && ((addr & MASK_W) == BASE_W);
endmodule

// File: rtl/cs_stretch_fsm.sv
module cs_stretch_fsm
    import cs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] ph,
    input  logic            e1m,
    input  logic            e1m_fall,
    input  logic            slow_in,
    input  logic            rnw_in,
    output logic            phi2,
    output logic            phi2_fall,
    output logic            cyc_start,
    output logic            slow_q,
    output logic            rnw_q
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_TCK - 1);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

    cs_state_e st, st_nx;
    logic      first_tick;

    always_comb first_tick = (st == ST_LOW) && (ph[1:0] == 2'd0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_LOW;
            slow_q <= 1'b0;
            rnw_q  <= 1'b1;
        end else begin
            st <= st_nx;
            if (first_tick) begin
                slow_q <= slow_in;
                rnw_q  <= rnw_in;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_LOW: begin
                if (ph[1:0] == 2'd1) begin
                    if (!slow_q)               st_nx = ST_HIGH;
                    else if (!ph[PH_W-1])      st_nx = ST_FHIGH;
                    else                       st_nx = ST_WAIT;
                end
            end
            ST_HIGH:  if (ph[1:0] == 2'd3)  st_nx = ST_LOW;
            ST_WAIT:  if (ph == PH_LAST)    st_nx = ST_FLOW;
            ST_FLOW:  if (ph == PH_ONE)     st_nx = ST_FHIGH;
            ST_FHIGH: if (ph == PH_LAST)    st_nx = ST_LOW;
            default:                        st_nx = ST_LOW;
        endcase
    end

    always_comb begin
        phi2      = (st == ST_HIGH) || (st == ST_FHIGH);
        phi2_fall = ((st == ST_HIGH) && (ph[1:0] == 2'd3)) ||
                    ((st == ST_FHIGH) && (ph == PH_LAST));
        cyc_start = first_tick;
    end

    AST_SLOW_ENDS_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2_fall && slow_q) |-> e1m_fall) else $error("shared edge"); // R5
    AST_WAIT_ONLY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> e1m) else $error("wait phase"); // R6
    AST_FAST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIGH) |-> !slow_q) else $error("fast high"); // R4
    AST_START_NOT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |-> !phi2) else $error("start level"); // R11
endmodule

// File: rtl/cs_stall_meter.sv
module cs_stall_meter #(
    parameter int STALL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_start,
    input  logic               phi2_fall,
    input  logic               slow_q,
    output logic [STALL_W-1:0] stall_cnt,
    output logic               stall_vld
);
    localparam logic [STALL_W-1:0] BASE_LEN = STALL_W'(cs_pkg::FAST_TCK - 1);

    logic [STALL_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q     <= '0;
            stall_cnt <= '0;
            stall_vld <= 1'b0;
        end else begin
            len_q     <= phi2_fall ? '0 : len_q + 1'b1;
            stall_vld <= phi2_fall && slow_q;
            if (phi2_fall && slow_q) stall_cnt <= len_q - BASE_LEN;
        end
    end

    AST_STALL_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        stall_vld |-> (stall_cnt == STALL_W'(4) || stall_cnt == STALL_W'(8))) else $error("stall"); // R9
    AST_FAST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2_fall && !slow_q) |-> (len_q == BASE_LEN)) else $error("fast len"); // R3
    AST_VLD_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        stall_vld |-> cyc_start) else $error("stall timing"); // R9
endmodule

// File: rtl/cycle_stretcher.sv
module cycle_stretcher #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] SLOW_BASE = 16'hFE00,
    parameter logic [15:0] SLOW_MASK = 16'hFF00,
    parameter int          STALL_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rnw,
    input  logic               bus_act,
    input  logic               vid_fast,
    output logic               phi2,
    output logic               phi2_fall,
    output logic               cyc_start,
    output logic               e1m,
    output logic               e1m_fall,
    output logic               dev_cs_n,
    output logic               dev_wr,
    output logic               vid_ce,
    output logic [STALL_W-1:0] stall_cnt,
    output logic               stall_vld
);
    import cs_pkg::*;

    logic [PH_W-1:0] ph;
    logic            slow_in, slow_q, rnw_q;
    logic            match_n, phi1;

    cs_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .vid_fast (vid_fast),
        .ph       (ph),
        .e1m      (e1m),
        .e1m_fall (e1m_fall),
        .vid_ce   (vid_ce)
    );

    cs_slow_decode #(
        .ADDR_W    (ADDR_W),
        .SLOW_BASE (SLOW_BASE),
        .SLOW_MASK (SLOW_MASK)
    ) u_dec (
        .addr (cpu_addr),
        .act  (bus_act),
        .slow (slow_in)
    );

    cs_stretch_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .e1m       (e1m),
        .e1m_fall  (e1m_fall),
        .slow_in   (slow_in),
        .rnw_in    (cpu_rnw),
        .phi2      (phi2),
        .phi2_fall (phi2_fall),
        .cyc_start (cyc_start),
        .slow_q    (slow_q),
        .rnw_q     (rnw_q)
    );

    cs_stall_meter #(.STALL_W(STALL_W)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .phi2_fall (phi2_fall),
        .slow_q    (slow_q),
        .stall_cnt (stall_cnt),
        .stall_vld (stall_vld)
    );

    // Select is the region match ORed with the low CPU phase, active low.
    always_comb begin
        match_n  = !slow_q;
        phi1     = !phi2;
        dev_cs_n = match_n || phi1;
        dev_wr   = !dev_cs_n && !rnw_q && e1m_fall;
    end

    AST_CS_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_cs_n |-> phi2) else $error("cs phase"); // R7
    AST_WR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (phi2_fall && e1m)) else $error("write edge"); // R8
    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_cs_n && phi2_fall) |=> dev_cs_n) else $error("cs release"); // R7
endmodule

// File: tb/cycle_stretcher_test.sv
module cycle_stretcher_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rnw = 1'b1;
    logic        bus_act = 1'b0;
    logic        vid_fast = 1'b0;
    logic        phi2, phi2_fall, cyc_start, e1m, e1m_fall, dev_cs_n, dev_wr, vid_ce, stall_vld;
    logic [3:0]  stall_cnt;

    int checks = 0;
    int fails  = 0;
    int t      = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cycle_stretcher uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
        .bus_act(bus_act), .vid_fast(vid_fast), .phi2(phi2), .phi2_fall(phi2_fall),
        .cyc_start(cyc_start), .e1m(e1m), .e1m_fall(e1m_fall), .dev_cs_n(dev_cs_n),
        .dev_wr(dev_wr), .vid_ce(vid_ce), .stall_cnt(stall_cnt), .stall_vld(stall_vld)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
        t++;
    endtask

    function automatic bit is_slow(input bit act, input logic [15:0] a);
        return act && ((a & 16'hFF00) == 16'hFE00);
    endfunction

    function automatic int cyc_len(input bit slow, input int start);
        if (!slow) return 4;
        return ((start % 8) == 0) ? 8 : 12;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        bit          prev_slow = 0;
        int          prev_len  = 0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        check(phi2 == 0 && dev_cs_n == 1 && e1m == 0 && dev_wr == 0 && stall_vld == 0,
              "R1 in reset", {phi2, dev_cs_n, e1m, dev_wr, stall_vld}, 5'b01000);
        rst_n = 1'b1;
        t = 0;
        // R1: first tick after release
        check(cyc_start == 1 && phi2 == 0 && dev_cs_n == 1 && e1m == 0,
              "R1 first tick", {cyc_start, phi2, dev_cs_n, e1m}, 4'b1010);

        for (int n = 0; n < 420; n++) begin
            logic [15:0] a;
            bit act, rnw, slow;
            int len, start;
            int e_phi, e_cs, e_wr, e_fall, e_e1, e_vid, e_st;
            if (n == 0)      begin a = 16'hFE01; act = 1; rnw = 0; end // even slow write
            else if (n == 1) begin a = 16'hFDFF; act = 1; rnw = 1; end // below region
            else if (n == 2) begin a = 16'hFE00; act = 1; rnw = 1; end // odd slow read
            else if (n == 3) begin a = 16'hFE05; act = 0; rnw = 0; end // inactive
            else if (n == 4) begin a = 16'hFF00; act = 1; rnw = 0; end // above region
            else if (n == 5) begin a = 16'hFEFF; act = 1; rnw = 0; end // slow write
            else begin
                a   = ($urandom % 3 == 0) ? 16'($urandom) : (16'hFE00 | 16'($urandom % 256));
                act = ($urandom % 10) != 0;
                rnw = $urandom % 2;
            end
            vid_fast = (n < 6) ? n[0] : 1'($urandom % 2);
            cpu_addr = a; cpu_rnw = rnw; bus_act = act;
            slow  = is_slow(act, a);
            start = t;
            len   = cyc_len(slow, start);
            // R11: cycle start phase and strobe
            check(cyc_start == 1 && (start % 4) == 0, "R11 start", int'(cyc_start), 1);
            // R9: report from previous cycle
            if (n > 0) begin
                if (prev_slow)
                    check(stall_vld == 1 && int'(stall_cnt) == prev_len - 4, "R9 stall",
                          int'(stall_cnt), prev_len - 4);
                else
                    check(stall_vld == 0, "R9 no stall after fast", int'(stall_vld), 0);
            end
            e_phi = 0; e_cs = 0; e_wr = 0; e_fall = 0; e_e1 = 0; e_vid = 0; e_st = 0;
            for (int i = 0; i < len; i++) begin
                bit xp;
                if (i > 0) step();
                xp = slow ? (i >= len - 6) : (i >= 2);
                if (phi2 != xp) e_phi++;
                if (dev_cs_n != !(slow && xp)) e_cs++;
                if (dev_wr != (slow && !rnw && i == len - 1)) e_wr++;
                if (phi2_fall != (i == len - 1)) e_fall++;
                if (e1m != ((t % 8) >= 4) || e1m_fall != ((t % 8) == 7)) e_e1++;
                if (vid_ce != (((t % 8) == 7) || (vid_fast && (t % 8) == 3))) e_vid++;
                if (i > 0 && cyc_start) e_st++;
            end
            if (slow) begin
                check(e_phi == 0, ((start % 8) == 0) ? "R6 even phi2 shape" : "R6 odd phi2 shape", e_phi, 0);
                check(e_fall == 0 && e1m_fall == 1, "R5 shared end edge", e_fall, 0);
            end else begin
                check(e_phi == 0, act ? "R4 R3 fast phi2 shape" : "R4 inactive is fast", e_phi, 0);
                check(e_fall == 0, "R3 fast end", e_fall, 0);
            end
            check(e_cs == 0, "R7 chip select", e_cs, 0);
            check(e_wr == 0, "R8 write commit", e_wr, 0);
            check(e_e1 == 0, "R2 e1m phase", e_e1, 0);
            check(e_vid == 0, "R10 video enable", e_vid, 0);
            check(e_st == 0, "R11 single start", e_st, 0);
            prev_slow = slow;
            prev_len  = len;
            step();
        end
        done = 1;
        summary();
    end
endmodule